// File: doc/BRIEF.md
# General Purpose Pin Bank with Edge Interrupts

This block runs a bank of general purpose pins behind a small synchronous register bus. Software sets each pin as a plain input, a driven output or an edge-interrupt input. It also picks a rising or falling trigger per pin, unmasks the pins it wants and switches a per-pin pull-up. Pins are presented as separate input, output and output-enable vectors, so the pad ring stays outside the block.

Every pin input goes through a two-flop synchroniser. An edge is found by comparing the synchronised level with the one from the previous cycle. A matching edge on an interrupt pin sets a sticky status bit, and software clears that bit by writing 1 to it. A single interrupt line is raised while any unmasked status bit is set. A global power-down bit gates all inputs and releases all output enables, so the pins float.

Top module: `gpio_bank`

## Requirements
- R1: After reset the direction, interrupt-mode, enable, polarity, pull-up, output latch, status and power-down registers all read 0. `pin_oe_o`, `pull_en_o` and `irq_o` are 0.
- R2: The address map is 0 data, 1 direction, 2 interrupt mode, 3 interrupt enable, 4 polarity, 5 status, 6 pull-up, 7 control. A direction bit of 1 makes the pin an output, with `pin_oe_o` set for it. `pin_o` always carries the output latch and changes only on a write to address 0.
- R3: Reading address 0 returns the latch bit for output pins and the synchronised pin level for input pins. A change on `pin_i` becomes visible on the read after two rising clock edges.
- R4: A polarity bit of 1 selects the rising edge and 0 selects the falling edge. The opposite edge does not set status. Status is visible after the third rising edge following the pin change.
- R5: Status is set only for pins whose direction bit is 0 and whose interrupt-mode bit is 1.
- R6: Status bits stay set until written with 1 at address 5. Bits written with 0 are unchanged. When a clear and a new edge on the same pin fall in the same cycle, the bit stays set.
- R7: `irq_o` is 1 exactly when some status bit is set and its enable bit is 1. Masked pins still latch status.
- R8: `pull_en_o` equals the pull-up register and changes only on a write to address 6.
- R9: While control bit 0 (power-down) is 1, `pin_oe_o` is all zero, input pins read 0 and no status bit is set. Leaving power-down with steady pins sets no status.
- R10: Addresses 1, 2, 3, 4 and 6 read back the last value written. Address 7 reads power-down in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | N_PINS | Write data |
| rdata_o | output | N_PINS | Read data, combinational on addr_i |
| pin_i | input | N_PINS | Pin levels from pads |
| pin_o | output | N_PINS | Output latch to pads |
| pin_oe_o | output | N_PINS | Output enable per pin |
| pull_en_o | output | N_PINS | Pull-up enable per pin |
| irq_o | output | 1 | Combined interrupt |

## Verification
A write-1 clear of the status register can land in the same cycle as the setting of a status bit by a detected edge. The bench provokes this by raising a pin and then holding the clear write so that it coincides with the third rising edge after the pin change. In the same write it also clears a second bit that has no new edge. The bench expects the colliding bit to stay set and the quiet bit to clear, and it judges the result by reading the status register back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_IRQM = 3'd2,
    REG_IEN  = 3'd3,
    REG_POL  = 3'd4,
    REG_STAT = 3'd5,
    REG_PULL = 3'd6,
    REG_CTRL = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_edge.sv
module gpio_edge #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] irq_mode_i,
  input  logic [W-1:0] pol_i,
  input  logic         pd_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] prev_q, status_q, hit;

  // prev keeps tracking during power-down so exit creates no false edge
  always_comb begin
    for (int i = 0; i < W; i++) begin
      hit[i] = irq_mode_i[i] & ~pd_i &
               (pol_i[i] ? (lvl_i[i] & ~prev_q[i]) : (~lvl_i[i] & prev_q[i]));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q   <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= lvl_i;
      status_q <= (status_q & ~clr_i) | hit;  // set wins
    end
  end

  assign status_o = status_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      lvl_i,
  input  logic [W-1:0]      status_i,
  output logic [W-1:0]      out_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      irqm_o,
  output logic [W-1:0]      ien_o,
  output logic [W-1:0]      pol_o,
  output logic [W-1:0]      pull_o,
  output logic              pd_o,
  output logic [W-1:0]      clr_o
);
  logic [W-1:0] out_q, dir_q, irqm_q, ien_q, pol_q, pull_q;
  logic         pd_q;
  gpio_reg_e    sel;

  assign sel = gpio_reg_e'(addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      irqm_q <= '0;
      ien_q  <= '0;
      pol_q  <= '0;
      pull_q <= '0;
      pd_q   <= 1'b0;
    end else if (wr_en_i) begin
      case (sel)
        REG_DATA: out_q  <= wdata_i;
        REG_DIR:  dir_q  <= wdata_i;
        REG_IRQM: irqm_q <= wdata_i;
        REG_IEN:  ien_q  <= wdata_i;
        REG_POL:  pol_q  <= wdata_i;
        REG_PULL: pull_q <= wdata_i;
        REG_CTRL: pd_q   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_en_i && sel == REG_STAT) ? wdata_i : '0;

  always_comb begin
    case (sel)
      REG_DATA: rdata_o = (dir_q & out_q) | (~dir_q & lvl_i & {W{~pd_q}});
      REG_DIR:  rdata_o = dir_q;
      REG_IRQM: rdata_o = irqm_q;
      REG_IEN:  rdata_o = ien_q;
      REG_POL:  rdata_o = pol_q;
      REG_STAT: rdata_o = status_i;
      REG_PULL: rdata_o = pull_q;
      default:  rdata_o = {{(W-1){1'b0}}, pd_q};
    endcase
  end

  assign out_o  = out_q;
  assign dir_o  = dir_q;
  assign irqm_o = irqm_q;
  assign ien_o  = ien_q;
  assign pol_o  = pol_q;
  assign pull_o = pull_q;
  assign pd_o   = pd_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o,
  output logic [N_PINS-1:0] pull_en_o,
  output logic              irq_o
);
  logic [N_PINS-1:0] lvl_w, status_w, clr_w, dir_w, irqm_w, ien_w, pol_w;
  logic [N_PINS-1:0] irq_mode_w;
  logic              pd_w;

  gpio_sync #(.W(N_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(lvl_w)
  );

  gpio_regs #(.W(N_PINS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .lvl_i(lvl_w), .status_i(status_w),
    .out_o(pin_o), .dir_o(dir_w), .irqm_o(irqm_w), .ien_o(ien_w),
    .pol_o(pol_w), .pull_o(pull_en_o), .pd_o(pd_w), .clr_o(clr_w)
  );

  assign irq_mode_w = ~dir_w & irqm_w;

  gpio_edge #(.W(N_PINS)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl_w), .irq_mode_i(irq_mode_w),
    .pol_i(pol_w), .pd_i(pd_w), .clr_i(clr_w), .status_o(status_w)
  );

  assign pin_oe_o = dir_w & {N_PINS{~pd_w}};
  assign irq_o    = |(status_w & ien_w);
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int N_PINS = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [2:0]        addr_i,
  input logic              wr_en_i,
  input logic [N_PINS-1:0] pin_o,
  input logic [N_PINS-1:0] pin_oe_o,
  input logic [N_PINS-1:0] pull_en_o,
  input logic [N_PINS-1:0] status,
  input logic [N_PINS-1:0] irq_mode,
  input logic              pd
);
  assert_latch_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 3'd0) |=> $stable(pin_o));

  assert_pull_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 3'd6) |=> $stable(pull_en_o));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 3'd5) |=> ((status & $past(status)) == $past(status)));

  assert_mode_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status & ~$past(status) & ~$past(irq_mode)) == '0));

  assert_pd_no_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |=> ((status & ~$past(status)) == '0));

  assert_pd_float_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> (pin_oe_o == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.N_PINS(N_PINS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
  .pin_o(pin_o), .pin_oe_o(pin_oe_o), .pull_en_o(pull_en_o),
  .status(status_w), .irq_mode(irq_mode_w), .pd(pd_w)
);

// File: tb/gpio_bank_test.sv
module gpio_bank_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   addr = '0;
  logic         wr_en = 1'b0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata, pin_in, pin_out, pin_oe, pull_en;
  logic         irq;
  int           checks = 0;
  int           failures = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  gpio_bank #(.N_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_in), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .pull_en_o(pull_en), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] dir, irqm, pol, ien, pin_a, pin_b, exp_st;
    logic       exp_irq;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h0F, 8'h0F, 1'b1},
    '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'hF0, 8'h0F, 1'b1},
    '{8'h00, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0},
    '{8'h00, 8'hFF, 8'hAA, 8'hFF, 8'h00, 8'hFF, 8'hAA, 1'b1},
    '{8'h00, 8'hFF, 8'hAA, 8'hFF, 8'hFF, 8'h00, 8'h55, 1'b1},
    '{8'h00, 8'h0F, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h0F, 1'b1},
    '{8'hF0, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h0F, 1'b1},
    '{8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'hFF, 1'b0},
    '{8'h00, 8'hFF, 8'hFF, 8'h80, 8'h00, 8'h01, 8'h01, 1'b0},
    '{8'h00, 8'hFF, 8'hFF, 8'h81, 8'h00, 8'h01, 8'h01, 1'b1}
  };

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 1; a < 8; a++) begin
      rd(a[2:0], v);
      chk("R1 reset reg", v, '0);
    end
    chk("R1 oe", pin_oe, '0);
    chk("R1 pull", pull_en, '0);
    chk("R1 irq", {7'd0, irq}, '0);
    chk("R1 latch", pin_out, '0);

    // R10 readback, R8 pull output
    wr(3'd1, 8'h3C); wr(3'd2, 8'hA5); wr(3'd3, 8'h5A); wr(3'd4, 8'hC3); wr(3'd6, 8'h96);
    rd(3'd1, v); chk("R10 dir", v, 8'h3C);
    rd(3'd2, v); chk("R10 irqm", v, 8'hA5);
    rd(3'd3, v); chk("R10 ien", v, 8'h5A);
    rd(3'd4, v); chk("R10 pol", v, 8'hC3);
    rd(3'd6, v); chk("R10 pull", v, 8'h96);
    chk("R8 pull out", pull_en, 8'h96);
    wr(3'd7, 8'hFE);
    rd(3'd7, v); chk("R10 ctrl bit0 only", v, 8'h00);

    // R2 direction and latch, R3 data read
    wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h0F); wr(3'd0, 8'hA5);
    chk("R2 oe", pin_oe, 8'h0F);
    chk("R2 pin_o", pin_out, 8'hA5);
    pin_in = 8'h3C;
    @(posedge clk); @(negedge clk);
    rd(3'd0, v); chk("R3 one edge not yet", v, 8'h05);
    @(posedge clk); @(negedge clk);
    rd(3'd0, v); chk("R3 mixed read", v, 8'h35);

    // R4 R5 R7 vector table
    for (int i = 0; i < 10; i++) begin
      wr(3'd1, VECS[i].dir); wr(3'd2, VECS[i].irqm);
      wr(3'd4, VECS[i].pol); wr(3'd3, VECS[i].ien);
      pin_in = VECS[i].pin_a;
      settle(4);
      wr(3'd5, 8'hFF);
      pin_in = VECS[i].pin_b;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rd(3'd5, v); chk($sformatf("R4/R5 vec%0d status", i), v, VECS[i].exp_st);
      chk($sformatf("R7 vec%0d irq", i), {7'd0, irq}, {7'd0, VECS[i].exp_irq});
    end

    // R6 clear semantics and collision
    wr(3'd1, 8'h00); wr(3'd2, 8'hFF); wr(3'd4, 8'hFF); wr(3'd3, 8'hFF);
    pin_in = 8'h00; settle(4); wr(3'd5, 8'hFF);
    pin_in = 8'h03; settle(4);
    rd(3'd5, v); chk("R6 set", v, 8'h03);
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R6 zero write", v, 8'h03);
    pin_in = 8'h00; settle(4);
    rd(3'd5, v); chk("R6 sticky", v, 8'h03);
    pin_in = 8'h01;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    addr = 3'd5; wdata = 8'h03; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    rd(3'd5, v); chk("R6 set wins", v, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R6 clear", v, 8'h00);
    chk("R7 irq low", {7'd0, irq}, '0);

    // R9 power-down
    pin_in = 8'h00; settle(4);
    wr(3'd7, 8'h01);
    rd(3'd7, v); chk("R10 ctrl", v, 8'h01);
    pin_in = 8'hFF; settle(4);
    rd(3'd0, v); chk("R9 inputs gated", v, 8'h00);
    rd(3'd5, v); chk("R9 no status", v, 8'h00);
    wr(3'd1, 8'hFF);
    chk("R9 outputs float", pin_oe, 8'h00);
    wr(3'd1, 8'h00);
    wr(3'd7, 8'h00);
    settle(4);
    rd(3'd5, v); chk("R9 no spurious on exit", v, 8'h00);
    rd(3'd0, v); chk("R9 inputs restored", v, 8'hFF);
    wr(3'd4, 8'h00);
    pin_in = 8'h00; settle(4);
    rd(3'd5, v); chk("R4 falling after exit", v, 8'hFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule